// File: doc/BRIEF.md
# UART Control and Status Register Bank

This block is the software-visible register file of a 16550-style serial port. It decodes 16-bit bus accesses to twelve registers at a 4-byte word stride. It holds the baud divisor halves, the global, line and modem control words, a scratch word and the interrupt-enable word. The enable word is changed only through a pair of set and clear aliases. Errors and events latched in the line status and modem status words are cleared by writing ones. Reads never clear them.

The serializer side is kept outside the block and reached through plain signals. The receiver supplies the next received byte and live data-ready state, and takes a pop strobe when software reads the receive buffer. The transmitter supplies live holding-register-empty and idle state, and is handed each byte written to the transmit holding register as a one-cycle load strobe. When the transmit-empty interrupt is enabled, that load is paired with a transmit event pulse. Receive errors, transmit completion and clear-to-send changes arrive as one-cycle set pulses.

An access is sampled on the rising clock edge where `busSel` is high. Read data and the error code for that access appear after that edge and stay until the next edge. Read data is held until the next successful read.

Top module: `uart_reg_bank`

## Requirements
- R1: After reset, the divisor low register reads 0x0001. Line status reads 0x0060 while the transmitter reports holding-empty and idle and no byte is ready. Every other register reads 0x0000.
- R2: Byte offsets are 4 times the word index: divisor low 0, divisor high 1, global control 2, line control 3, modem control 4, line status 5, modem status 6, scratch 7, enable-set 8, enable-clear 9, transmit holding 10, receive buffer 11. Divisor low/high, global, line and modem control and scratch read back the full 16-bit value last written to them.
- R3: An access with `busSize` other than 1 (16-bit) gives `busErr` = 1 and changes nothing. The size check takes priority over the offset check.
- R4: A 16-bit access with `busAddr[1:0]` not zero, or with a word index of 12 or more, gives `busErr` = 2 and changes nothing. Accepted accesses give `busErr` = 0.
- R5: A write to enable-set ORs the data into the enable word. A write to enable-clear clears every enable bit written as 1. A read of either offset returns the enable word.
- R6: Line status bits 1 (overrun), 2 (parity), 3 (framing), 4 (break) and 7 (transmit finished) are cleared by writing 1 to them. A write to line status changes no other bit.
- R7: A line status read returns bit 0 = `rxReady`, bit 5 = `thrEmpty` and bit 6 = `txIdle`, taken in the access cycle. Bits 15:8 read zero.
- R8: Modem status bit 0 is set by a `ctsChange` pulse and cleared by writing 1. Its other bits read zero and are not affected by writes.
- R9: A receive buffer read returns `rxByte` in bits 7:0 and raises `rxPop` in the access cycle only. A write to that offset raises no pop, no load and no error, and alters no register.
- R10: A transmit holding write raises `txLoad` for one cycle after the access, with `txData` equal to the written bits 7:0. `txEvent` pulses in the same cycle only if enable bit 1 was set at the write. Reading that offset returns the last written 16-bit value.
- R11: The pulses `rxOverrun`, `rxParityErr`, `rxFrameErr`, `rxBreak` and `txDone` set line status bits 1, 2, 3, 4 and 7. A set pulse wins over a clearing write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset within the bank |
| busSize | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data of the last accepted read |
| busErr | output | 2 | Status of the previous access: 0 ok, 1 size, 2 unmapped |
| rxByte | input | 8 | Next received byte |
| rxReady | input | 1 | Live data-ready from the receiver |
| rxPop | output | 1 | Receive byte consumed this cycle |
| thrEmpty | input | 1 | Live transmit holding empty |
| txIdle | input | 1 | Live transmitter empty |
| txData | output | 8 | Byte for the transmitter |
| txLoad | output | 1 | One-cycle load strobe for `txData` |
| txEvent | output | 1 | Transmit event when transmit interrupt enabled |
| rxOverrun | input | 1 | Set pulse, line status bit 1 |
| rxParityErr | input | 1 | Set pulse, line status bit 2 |
| rxFrameErr | input | 1 | Set pulse, line status bit 3 |
| rxBreak | input | 1 | Set pulse, line status bit 4 |
| txDone | input | 1 | Set pulse, line status bit 7 |
| ctsChange | input | 1 | Set pulse, modem status bit 0 |

## Verification
The bench builds the bank with its defaults: a 6-bit byte offset and a 16-bit data word. With a 6-bit offset, random word indices 0 to 15 reach all twelve mapped registers and the four unmapped slots above them. Misaligned offsets and non-16-bit sizes are mixed in, so both error codes and their priority occur often. The full 16-bit data width lets the set/clear enable logic and the upper bits of line and modem status be shown to stay clear under random data.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int NUM_REGS   = 12;
  localparam int IER_TX_BIT = 1;

  typedef enum logic [3:0] {
    IDX_DLL  = 4'd0,  IDX_DLH = 4'd1, IDX_GCTL = 4'd2, IDX_LCR = 4'd3,
    IDX_MCR  = 4'd4,  IDX_LSR = 4'd5, IDX_MSR  = 4'd6, IDX_SCR = 4'd7,
    IDX_IES  = 4'd8,  IDX_IEC = 4'd9, IDX_THR  = 4'd10, IDX_RBR = 4'd11
  } regIdx_t;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0, ERR_SIZE = 2'd1, ERR_MAP = 2'd2
  } accErr_t;

  // strobes handed from decode to the datapath
  typedef struct packed {
    logic    wr;
    logic    rd;
    regIdx_t idx;
    accErr_t err;
  } strobe_t;
endpackage

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output strobe_t           stb
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             misaligned;
  logic             beyondMap;

  assign wordIdx    = busAddr[ADDR_W-1:2];
  assign misaligned = |busAddr[1:0];
  assign beyondMap  = (wordIdx >= IDX_W'(NUM_REGS));

  always_comb begin
    stb = '0;
    if (busSel) begin
      if (busSize != 2'd1) begin
        stb.err = ERR_SIZE;        // size is judged before the offset
      end else if (misaligned || beyondMap) begin
        stb.err = ERR_MAP;
      end else begin
        stb.wr  = busWrite;
        stb.rd  = !busWrite;
        stb.idx = regIdx_t'(wordIdx[3:0]);
      end
    end
  end
endmodule

// File: rtl/uart_reg_dpath.sv
module uart_reg_dpath
  import uart_reg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        errCode,
  input  logic [7:0]        rxByte,
  input  logic              rxReady,
  output logic              rxPop,
  input  logic              thrEmpty,
  input  logic              txIdle,
  output logic [7:0]        txData,
  output logic              txLoad,
  output logic              txEvent,
  input  logic [4:0]        stickySet,   // {txDone, break, frame, parity, overrun}
  input  logic              ctsChange
);
  localparam int NUM_CFG = 5;            // divisor low/high, global, line, modem
  localparam int PAD_W   = DATA_W - 8;

  logic [DATA_W-1:0] cfgReg [NUM_CFG];
  logic [DATA_W-1:0] scrReg, ierReg, thrReg, rdMux, rdataQ;
  logic [4:0]        stickyQ, stickyClr;
  logic              ctsQ, ctsClr, txLoadQ, txEventQ, thrWrite;
  logic [1:0]        errQ;

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    localparam logic [DATA_W-1:0] RST_VAL = (i == 0) ? DATA_W'(1) : '0;
    always_ff @(posedge clk) begin
      if (!rstN)                                      cfgReg[i] <= RST_VAL;
      else if (stb.wr && stb.idx == regIdx_t'(4'(i))) cfgReg[i] <= wdata;
    end
  end

  assign thrWrite  = stb.wr && stb.idx == IDX_THR;
  assign stickyClr = (stb.wr && stb.idx == IDX_LSR) ? {wdata[7], wdata[4:1]} : 5'd0;
  assign ctsClr    = stb.wr && stb.idx == IDX_MSR && wdata[0];
  assign rxPop     = stb.rd && stb.idx == IDX_RBR;

  always_comb begin
    unique case (stb.idx)
      IDX_DLL:          rdMux = cfgReg[0];
      IDX_DLH:          rdMux = cfgReg[1];
      IDX_GCTL:         rdMux = cfgReg[2];
      IDX_LCR:          rdMux = cfgReg[3];
      IDX_MCR:          rdMux = cfgReg[4];
      IDX_LSR:          rdMux = {{PAD_W{1'b0}}, stickyQ[4], txIdle, thrEmpty,
                                 stickyQ[3:0], rxReady};
      IDX_MSR:          rdMux = {{(DATA_W-1){1'b0}}, ctsQ};
      IDX_SCR:          rdMux = scrReg;
      IDX_IES, IDX_IEC: rdMux = ierReg;
      IDX_THR:          rdMux = thrReg;
      IDX_RBR:          rdMux = {{PAD_W{1'b0}}, rxByte};
      default:          rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scrReg   <= '0;
      ierReg   <= '0;
      thrReg   <= '0;
      stickyQ  <= '0;
      ctsQ     <= 1'b0;
      rdataQ   <= '0;
      errQ     <= 2'd0;
      txLoadQ  <= 1'b0;
      txEventQ <= 1'b0;
    end else begin
      if (stb.wr) begin
        case (stb.idx)
          IDX_SCR: scrReg <= wdata;
          IDX_IES: ierReg <= ierReg | wdata;
          IDX_IEC: ierReg <= ierReg & ~wdata;
          IDX_THR: thrReg <= wdata;
          default: ;
        endcase
      end
      stickyQ  <= (stickyQ & ~stickyClr) | stickySet;   // set wins
      ctsQ     <= (ctsQ & ~ctsClr) | ctsChange;
      txLoadQ  <= thrWrite;
      txEventQ <= thrWrite && ierReg[IER_TX_BIT];
      if (stb.rd) rdataQ <= rdMux;
      errQ     <= stb.err;
    end
  end

  assign rdata   = rdataQ;
  assign errCode = errQ;
  assign txData  = thrReg[7:0];
  assign txLoad  = txLoadQ;
  assign txEvent = txEventQ;
endmodule

// File: rtl/uart_reg_bank.sv
module uart_reg_bank
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [1:0]        busErr,
  input  logic [7:0]        rxByte,
  input  logic              rxReady,
  output logic              rxPop,
  input  logic              thrEmpty,
  input  logic              txIdle,
  output logic [7:0]        txData,
  output logic              txLoad,
  output logic              txEvent,
  input  logic              rxOverrun,
  input  logic              rxParityErr,
  input  logic              rxFrameErr,
  input  logic              rxBreak,
  input  logic              txDone,
  input  logic              ctsChange
);
  strobe_t stb;

  uart_reg_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busSize(busSize), .stb(stb)
  );

  uart_reg_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata),
    .rdata(busRdata), .errCode(busErr),
    .rxByte(rxByte), .rxReady(rxReady), .rxPop(rxPop),
    .thrEmpty(thrEmpty), .txIdle(txIdle),
    .txData(txData), .txLoad(txLoad), .txEvent(txEvent),
    .stickySet({txDone, rxBreak, rxFrameErr, rxParityErr, rxOverrun}),
    .ctsChange(ctsChange)
  );
endmodule

// File: rtl/uart_reg_bank_chk.sv
module uart_reg_bank_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic [1:0]        busErr,
  input logic              rxPop,
  input logic              txLoad,
  input logic              txEvent
);
  localparam logic [ADDR_W-1:0] THR_OFF = ADDR_W'(40);
  localparam logic [ADDR_W-1:0] RBR_OFF = ADDR_W'(44);

  // R3
  bad_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    busSel && busSize != 2'd1 |=> busErr == 2'd1);

  // R4
  misaligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    busSel && busSize == 2'd1 && busAddr[1:0] != 2'd0 |=> busErr == 2'd2);

  // R9
  pop_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> busSel && !busWrite && busSize == 2'd1 && busAddr == RBR_OFF);

  // R10
  event_with_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    txEvent |-> txLoad);

  // R10
  load_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |-> $past(busSel && busWrite && busSize == 2'd1 && busAddr == THR_OFF));
endmodule

bind uart_reg_bank uart_reg_bank_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busSize(busSize), .busErr(busErr),
  .rxPop(rxPop), .txLoad(txLoad), .txEvent(txEvent)
);

// File: tb/test_uart_reg_bank.sv
`timescale 1ns/1ps
module test_uart_reg_bank;
  localparam int AW = 6;
  localparam int DW = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic busSel = 0, busWrite = 0;
  logic [AW-1:0] busAddr = '0;
  logic [1:0] busSize = 2'd1;
  logic [DW-1:0] busWdata = '0, busRdata;
  logic [1:0] busErr;
  logic [7:0] rxByte = '0, txData;
  logic rxReady = 0, rxPop, thrEmpty = 1, txIdle = 1, txLoad, txEvent;
  logic rxOverrun = 0, rxParityErr = 0, rxFrameErr = 0, rxBreak = 0, txDone = 0, ctsChange = 0;

  int nChecks = 0, nErrors = 0;

  // bench model
  logic [DW-1:0] mCfg [5];
  logic [DW-1:0] mScr, mIer, mThr, mRd;
  logic [4:0] mSticky;
  logic mCts;

  always #10 clk = ~clk;   // 50 MHz

  uart_reg_bank #(.ADDR_W(AW), .DATA_W(DW)) i_uart_reg_bank (.*);

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] modelRead(input int idx);
    case (idx)
      0, 1, 2, 3, 4: return mCfg[idx];
      5:  return {8'h00, mSticky[4], txIdle, thrEmpty, mSticky[3:0], rxReady};
      6:  return {15'd0, mCts};
      7:  return mScr;
      8, 9: return mIer;
      10: return mThr;
      11: return {8'h00, rxByte};
      default: return '0;
    endcase
  endfunction

  function automatic string tagFor(input int idx);
    case (idx)
      5: return "R7";
      6: return "R8";
      8, 9: return "R5";
      10: return "R10";
      11: return "R9";
      default: return "R2";
    endcase
  endfunction

  // one access; entered and left at a falling edge. setv = {cts,txDone,brk,fe,pe,oe}
  task automatic access(input logic sel, input logic wr, input logic [AW-1:0] addr,
                        input logic [1:0] size, input logic [DW-1:0] wd, input logic [5:0] setv);
    int idx;
    logic [1:0] expErr;
    logic ok, expPop, expLoad, expEvt;
    string tag;
    idx = int'(addr[AW-1:2]);
    busSel = sel; busWrite = wr; busAddr = addr; busSize = size; busWdata = wd;
    {ctsChange, txDone, rxBreak, rxFrameErr, rxParityErr, rxOverrun} = setv;
    expErr = !sel ? 2'd0 : (size != 2'd1) ? 2'd1 :
             (addr[1:0] != 2'd0 || idx >= 12) ? 2'd2 : 2'd0;
    tag = (expErr == 2'd1) ? "R3" : (expErr == 2'd2) ? "R4" : tagFor(idx);
    ok = sel && expErr == 2'd0;
    expPop  = ok && !wr && idx == 11;
    expLoad = ok && wr && idx == 10;
    expEvt  = expLoad && mIer[1];
    #1;
    if (ok && !wr) mRd = modelRead(idx);
    if (ok && wr) begin
      case (idx)
        0, 1, 2, 3, 4: mCfg[idx] = wd;
        5: mSticky = mSticky & ~{wd[7], wd[4:1]};
        6: if (wd[0]) mCts = 1'b0;
        7: mScr = wd;
        8: mIer = mIer | wd;
        9: mIer = mIer & ~wd;
        10: mThr = wd;
        default: ;
      endcase
    end
    mSticky = mSticky | setv[4:0];
    mCts = mCts | setv[5];
    check("R9 rxPop", DW'(rxPop), DW'(expPop));
    @(negedge clk);
    {ctsChange, txDone, rxBreak, rxFrameErr, rxParityErr, rxOverrun} = '0;
    busSel = 1'b0;
    check({tag, " busErr"}, DW'(busErr), DW'(expErr));
    check({tag, " rdata"}, busRdata, mRd);
    check("R10 txLoad", DW'(txLoad), DW'(expLoad));
    check("R10 txEvent", DW'(txEvent), DW'(expEvt));
    if (expLoad) check("R10 txData", DW'(txData), DW'(wd[7:0]));
  endtask

  task automatic rd(input int idx);
    access(1'b1, 1'b0, AW'(idx * 4), 2'd1, '0, '0);
  endtask
  task automatic wrReg(input int idx, input logic [DW-1:0] d);
    access(1'b1, 1'b1, AW'(idx * 4), 2'd1, d, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 5; i++) mCfg[i] = (i == 0) ? 16'h0001 : 16'h0000;
    mScr = '0; mIer = '0; mThr = '0; mRd = '0; mSticky = '0; mCts = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values, with transmitter idle and nothing received
    check("R1 busErr", DW'(busErr), 16'h0);
    for (int i = 0; i < 12; i++) begin
      rd(i);
      if (i == 0) check("R1 dll", busRdata, 16'h0001);
      else if (i == 5) check("R1 lsr", busRdata, 16'h0060);
      else if (i != 11) check("R1 zero", busRdata, 16'h0000);
    end
    // R3 size error takes priority over an unmapped offset
    access(1'b1, 1'b1, AW'(61), 2'd2, 16'hffff, '0);
    check("R3 priority", DW'(busErr), 16'h1);
    // R5 set then clear enables
    wrReg(8, 16'h00a2); wrReg(9, 16'h0080); rd(9);
    check("R5 ier", busRdata, 16'h0022);
    // R10 transmit write with event enabled
    wrReg(10, 16'h1234);
    // R9 write to receive buffer changes nothing
    wrReg(11, 16'hbeef); rd(7);
    check("R9 write ignored", busRdata, 16'h0000);
    // R11 set pulse beats a clearing write in the same cycle
    access(1'b1, 1'b1, AW'(20), 2'd1, 16'h00ff, 6'b000100);
    rd(5);
    check("R11 set wins", busRdata & 16'h009e, 16'h0008);
    // R6 clearing the remaining latched bit
    wrReg(5, 16'h0008); rd(5);
    check("R6 cleared", busRdata & 16'h009e, 16'h0000);
    // R8 cts change then clear
    access(1'b1, 1'b0, AW'(0), 2'd1, '0, 6'b100000);
    rd(6); check("R8 set", busRdata, 16'h0001);
    wrReg(6, 16'hfffe); rd(6); check("R8 kept", busRdata, 16'h0001);
    wrReg(6, 16'h0001); rd(6); check("R8 cleared", busRdata, 16'h0000);
    // random mix
    for (int n = 0; n < 800; n++) begin
      logic [AW-1:0] a;
      logic [1:0] sz;
      logic [5:0] sv;
      a = AW'(($urandom % 16) * 4);
      if ($urandom % 16 == 0) a = a + AW'(1 + $urandom % 3);
      sz = ($urandom % 10 == 0) ? 2'(($urandom % 2) * 2 + ($urandom % 2) * 3 % 4) : 2'd1;
      for (int b = 0; b < 6; b++) sv[b] = ($urandom % 8 == 0);
      rxByte = 8'($urandom); rxReady = 1'($urandom);
      thrEmpty = 1'($urandom); txIdle = 1'($urandom);
      access(($urandom % 8) != 0, 1'($urandom), a, sz, DW'($urandom), sv);
    end
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule